// File: doc/BRIEF.md
# Touch Digitizer Converter Serial Port

This block models the digital half of a touch-screen converter's clocked serial port. It runs entirely on the serial clock that the host supplies. It works inside windows framed by an active-low chip select. While selected, the port watches the data input on rising clock edges for a 1 that marks the start of a command. It then takes in the remaining seven command bits: a three-bit channel, a resolution select, a reference select and a two-bit power code. The channel, resolution and reference fields change one by one as their bits arrive. The power code changes only once the whole command is in.

The last three command clocks form the acquisition window. The clock that completes the command begins the hold. On that clock the parallel sample input is captured and BUSY is raised for exactly one clock. The captured value is returned MSB first on the falling clock edges, behind fixed zero padding. A second command may be clocked in while the first result is still going out, after a lockout that depends on the resolution. Raising chip select drops the outputs and cancels whatever frame was running. Analog sampling, power control and switch control are not part of this block; the value to return arrives on a parallel input.

Top module: `tdz_serial_port`

## Requirements
- R1: While cs_n is high, out_en is 0 and dout and busy are held at 0, whatever din does. While cs_n is low, out_en is 1.
- R2: While no frame is running, a rising edge that samples din=0 starts nothing. busy, dout and acquiring stay 0.
- R3: A frame starts on the rising edge (edge 1) that samples din=1. Edges 2 to 8 then sample the command bits in this order: channel bit 2, channel bit 1, channel bit 0, low_res, single_ended, power bit 1, power bit 0. Each of chan_sel, low_res and single_ended takes its new bit right after the edge that samples it.
- R4: pwr_mode changes only on edge 8 of a completed command. A frame cancelled before edge 8 leaves it unchanged.
- R5: acquiring is 1 from edge 5 to edge 8 of a frame, which is three clocks, and 0 at all other times.
- R6: busy goes to 1 on the falling edge that follows edge 8 and back to 0 on the next falling edge. Only rising edge 9 sees busy high.
- R7: With low_res=0, the host sees dout=0 on rising edges 1 to 9, then result bits 11 down to 0 on edges 10 to 21, then 0 on edges 22 to 24.
- R8: With low_res=1, the host sees result bits 11 down to 4 on edges 10 to 17 and 0 on every other edge of the frame.
- R9: The result is the value on sample_data at edge 8. Later changes to sample_data do not alter the bits shifted out.
- R10: Raising cs_n cancels the frame in progress. After cs_n falls again, no result bits and no busy pulse from the cancelled frame appear. The command fields already written keep their values.
- R11: With low_res=0, a din=1 is not taken as a new start before edge 16 of the running frame. At edge 16 it starts a new frame, while the older result keeps shifting out.
- R12: With low_res=1, a din=1 is not taken as a new start before edge 12 of the running frame. At edge 12 it starts a new frame.
- R13: While cs_n stays low, a start bit after a finished frame begins a new conversion without any new chip-select framing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; commands are sampled on its rising edge, outputs change on its falling edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select; high cancels the frame |
| din | input | 1 | Serial command input |
| sample_data | input | 12 | Parallel value captured at hold |
| dout | output | 1 | Serial result output |
| busy | output | 1 | One-clock pulse at the start of hold |
| out_en | output | 1 | Output enable for dout and busy, high while selected |
| acquiring | output | 1 | High during the three-clock acquisition window |
| sample_hold | output | 1 | High for the clock after the capture edge |
| chan_sel | output | 3 | Channel field of the command |
| low_res | output | 1 | Resolution field, 1 selects the 8-bit result |
| single_ended | output | 1 | Reference-select field |
| pwr_mode | output | 2 | Power field, updated when the command completes |

## Verification
Some properties can be checked on every cycle. The assertions cover the quiet outputs while deselected and the single-clock width of busy. They also check that busy lines up with the capture, that acquisition runs straight into hold, and that the power field changes only on the completing edge. What the bench's scenarios alone can show are the bit positions in the serial output stream and the field values after each bit. They also cover the exact edges at which a second start bit is refused or taken, and the absence of leftovers after a cancelled frame. A sweep over every command word checks the first two with computed values. Directed sequences cover cancellation and both lockout boundaries.

// File: rtl/tdz_pkg.sv
package tdz_pkg;
   // command word layout (MSB first on the wire)
   localparam int CMD_BITS   = 8;
   localparam int CHAN_HI    = 6;
   localparam int CHAN_LO    = 4;
   localparam int RES_POS    = 3;
   localparam int REF_POS    = 2;
   localparam int PWR_BITS   = 2;
   localparam int CHAN_BITS  = CHAN_HI - CHAN_LO + 1;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/tdz_frame_seq.sv
module tdz_frame_seq #(
   parameter int CTRL_W  = 8,
   parameter int ACQ_CYC = 3,
   parameter int LOCK_HI = 7,
   parameter int LOCK_LO = 3,
   parameter int CNT_W   = 4
) (
   input  logic             sclk,
   input  logic             frame_rst_n,
   input  logic             din,
   input  logic             low_res,
   output logic             bit_we,
   output logic [CNT_W-1:0] bit_idx,
   output logic             word_done,
   output logic             acquiring
);
   localparam int THR_HI = CTRL_W + LOCK_HI;
   localparam int THR_LO = CTRL_W + LOCK_LO;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] thr;
   logic             hunting;

   assign thr     = low_res ? CNT_W'(THR_LO) : CNT_W'(THR_HI);
   assign hunting = (cnt_q == '0) || (cnt_q >= thr);

   // cnt_q holds the index of the last rising edge of the frame;
   // it parks at the threshold once the lockout has run out
   always_ff @(posedge sclk or negedge frame_rst_n) begin
      if (!frame_rst_n) begin
         cnt_q <= '0;
      end else if (hunting) begin
         if (din) cnt_q <= CNT_W'(1);
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign bit_we    = (cnt_q >= CNT_W'(1)) && (cnt_q <= CNT_W'(CTRL_W - 1));
   assign bit_idx   = cnt_q;
   assign word_done = (cnt_q == CNT_W'(CTRL_W - 1));
   assign acquiring = (cnt_q >= CNT_W'(CTRL_W - ACQ_CYC)) &&
                      (cnt_q <= CNT_W'(CTRL_W - 1));
endmodule

// File: rtl/tdz_ctrl_reg.sv
module tdz_ctrl_reg
   import tdz_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic                 sclk,
   input  logic                 rst_n,
   input  logic                 din,
   input  logic                 bit_we,
   input  logic [CNT_W-1:0]     bit_idx,
   input  logic                 word_done,
   output logic [CHAN_BITS-1:0] chan_sel,
   output logic                 low_res,
   output logic                 single_ended,
   output logic [PWR_BITS-1:0]  pwr_mode
);
   // stored command bits, START excluded; bit 0 (last power bit) goes
   // straight into the power register on the completing edge
   logic [CMD_BITS-2:1] word_q;
   logic [PWR_BITS-1:0] pwr_q;

   for (genvar j = 1; j <= CMD_BITS - 2; j++) begin : g_bit
      logic bit_q;
      always_ff @(posedge sclk or negedge rst_n) begin
         if (!rst_n)
            bit_q <= 1'b0;
         else if (bit_we && (bit_idx == CNT_W'(CMD_BITS - 1 - j)))
            bit_q <= din;
      end
      assign word_q[j] = bit_q;
   end

   always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n)
         pwr_q <= '0;
      else if (word_done)
         pwr_q <= {word_q[PWR_BITS-1:1], din};
   end

   assign chan_sel     = word_q[CHAN_HI:CHAN_LO];
   assign low_res      = word_q[RES_POS];
   assign single_ended = word_q[REF_POS];
   assign pwr_mode     = pwr_q;
endmodule

// File: rtl/tdz_result_tx.sv
module tdz_result_tx #(
   parameter int RES_W = 12,
   parameter int LOW_W = 8
) (
   input  logic             sclk,
   input  logic             frame_rst_n,
   input  logic             word_done,
   input  logic             low_res,
   input  logic [RES_W-1:0] sample_data,
   output logic             dout,
   output logic             busy,
   output logic             sample_hold
);
   localparam int LEFT_W = $clog2(RES_W + 1);

   logic [RES_W-1:0]  shreg_q;
   logic [LEFT_W-1:0] left_q;
   logic [LEFT_W-1:0] load_len;
   logic              lead_q;
   logic              hold_q;
   logic              dout_q;
   logic              busy_q;

   if (LOW_W == RES_W) begin : g_single
      assign load_len = LEFT_W'(RES_W);
   end else begin : g_dual
      assign load_len = low_res ? LEFT_W'(LOW_W) : LEFT_W'(RES_W);
   end

   // rising-edge side: capture, one spacer clock, then one shift per clock
   always_ff @(posedge sclk or negedge frame_rst_n) begin
      if (!frame_rst_n) begin
         shreg_q <= '0;
         left_q  <= '0;
         lead_q  <= 1'b0;
         hold_q  <= 1'b0;
      end else begin
         hold_q <= word_done;
         if (word_done) begin
            shreg_q <= sample_data;
            left_q  <= load_len;
            lead_q  <= 1'b1;
         end else if (lead_q) begin
            lead_q <= 1'b0;
         end else if (left_q != '0) begin
            shreg_q <= shreg_q << 1;
            left_q  <= left_q - LEFT_W'(1);
         end
      end
   end

   // falling-edge side: present the next bit and the busy pulse
   always_ff @(negedge sclk or negedge frame_rst_n) begin
      if (!frame_rst_n) begin
         dout_q <= 1'b0;
         busy_q <= 1'b0;
      end else begin
         busy_q <= hold_q;
         dout_q <= (!lead_q && (left_q != '0)) ? shreg_q[RES_W-1] : 1'b0;
      end
   end

   assign dout        = dout_q;
   assign busy        = busy_q;
   assign sample_hold = hold_q;
endmodule

// File: rtl/tdz_serial_port.sv
module tdz_serial_port
   import tdz_pkg::*;
#(
   parameter int RES_W   = 12,
   parameter int LOW_W   = 8,
   parameter int ACQ_CYC = 3,
   parameter int LOCK_HI = 7,
   parameter int LOCK_LO = 3
) (
   input  logic                 sclk,
   input  logic                 rst_n,
   input  logic                 cs_n,
   input  logic                 din,
   input  logic [RES_W-1:0]     sample_data,
   output logic                 dout,
   output logic                 busy,
   output logic                 out_en,
   output logic                 acquiring,
   output logic                 sample_hold,
   output logic [CHAN_BITS-1:0] chan_sel,
   output logic                 low_res,
   output logic                 single_ended,
   output logic [PWR_BITS-1:0]  pwr_mode
);
   localparam int CNT_MAX = max_int(CMD_BITS + LOCK_HI, CMD_BITS + LOCK_LO);
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   initial begin
      assert (LOW_W > 0 && LOW_W <= RES_W)
         else $error("LOW_W must lie in 1..RES_W");
      assert (ACQ_CYC >= 1 && ACQ_CYC < CMD_BITS)
         else $error("ACQ_CYC must lie in 1..CMD_BITS-1");
      assert (LOCK_HI >= 0 && LOCK_LO >= 0)
         else $error("lockout lengths must not be negative");
   end

   logic             frame_rst_n;
   logic             bit_we;
   logic [CNT_W-1:0] bit_idx;
   logic             word_done;

   assign frame_rst_n = rst_n & ~cs_n;
   assign out_en      = ~cs_n;

   tdz_frame_seq #(
      .CTRL_W (CMD_BITS),
      .ACQ_CYC(ACQ_CYC),
      .LOCK_HI(LOCK_HI),
      .LOCK_LO(LOCK_LO),
      .CNT_W  (CNT_W)
   ) u_seq (
      .sclk       (sclk),
      .frame_rst_n(frame_rst_n),
      .din        (din),
      .low_res    (low_res),
      .bit_we     (bit_we),
      .bit_idx    (bit_idx),
      .word_done  (word_done),
      .acquiring  (acquiring)
   );

   tdz_ctrl_reg #(
      .CNT_W(CNT_W)
   ) u_reg (
      .sclk        (sclk),
      .rst_n       (rst_n),
      .din         (din),
      .bit_we      (bit_we),
      .bit_idx     (bit_idx),
      .word_done   (word_done),
      .chan_sel    (chan_sel),
      .low_res     (low_res),
      .single_ended(single_ended),
      .pwr_mode    (pwr_mode)
   );

   tdz_result_tx #(
      .RES_W(RES_W),
      .LOW_W(LOW_W)
   ) u_tx (
      .sclk       (sclk),
      .frame_rst_n(frame_rst_n),
      .word_done  (word_done),
      .low_res    (low_res),
      .sample_data(sample_data),
      .dout       (dout),
      .busy       (busy),
      .sample_hold(sample_hold)
   );
endmodule

// File: rtl/tdz_serial_port_chk.sv
module tdz_serial_port_chk (
   input logic       sclk,
   input logic       rst_n,
   input logic       cs_n,
   input logic       dout,
   input logic       busy,
   input logic       acquiring,
   input logic       sample_hold,
   input logic [1:0] pwr_mode
);
   assert_quiet_deselected_R1: assert property (@(posedge sclk) disable iff (!rst_n)
      cs_n |-> (!dout && !busy));

   assert_busy_single_clock_R6: assert property (@(negedge sclk) disable iff (!rst_n)
      busy |=> !busy);

   assert_busy_with_hold_R6: assert property (@(posedge sclk) disable iff (!rst_n)
      (sample_hold && !cs_n) |-> busy);

   assert_pwr_on_completion_R4: assert property (@(posedge sclk) disable iff (!rst_n)
      !$stable(pwr_mode) |-> sample_hold);

   assert_acq_ends_in_hold_R5: assert property (@(posedge sclk) disable iff (!rst_n)
      $fell(acquiring) |-> (sample_hold || cs_n));

   assert_hold_after_acq_R5: assert property (@(posedge sclk) disable iff (!rst_n)
      $rose(sample_hold) |-> $past(acquiring));
endmodule

bind tdz_serial_port tdz_serial_port_chk u_chk (
   .sclk       (sclk),
   .rst_n      (rst_n),
   .cs_n       (cs_n),
   .dout       (dout),
   .busy       (busy),
   .acquiring  (acquiring),
   .sample_hold(sample_hold),
   .pwr_mode   (pwr_mode)
);

// File: tb/sim_tdz_serial_port.sv
module sim_tdz_serial_port;
   logic        sclk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        din = 1'b0;
   logic [11:0] sample_data = '0;
   logic        dout, busy, out_en, acquiring, sample_hold;
   logic [2:0]  chan_sel;
   logic        low_res, single_ended;
   logic [1:0]  pwr_mode;

   int checks = 0;
   int errors = 0;

   logic       stim     [1:64];
   logic       rec_dout [1:64];
   logic       rec_busy [1:64];
   logic       rec_acq  [1:64];
   logic       rec_oe   [1:64];
   logic [4:0] rec_fld  [1:64];
   logic [1:0] rec_pwr  [1:64];

   logic [4:0] cur_fld = '0;
   logic [1:0] cur_pwr = '0;

   tdz_serial_port u0 (
      .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .din(din),
      .sample_data(sample_data), .dout(dout), .busy(busy), .out_en(out_en),
      .acquiring(acquiring), .sample_hold(sample_hold), .chan_sel(chan_sel),
      .low_res(low_res), .single_ended(single_ended), .pwr_mode(pwr_mode)
   );

   always #10 sclk = ~sclk;

   task automatic check_eq(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic clear_stim();
      for (int k = 1; k <= 64; k++) stim[k] = 1'b0;
   endtask

   task automatic put_word(input int first, input logic [7:0] w);
      for (int i = 0; i < 8; i++) stim[first + i] = w[7 - i];
   endtask

   // drives stim[k] ahead of rising edge k and records what that edge sees
   task automatic run_seq(input int n, input int flip_at, input logic [11:0] alt);
      for (int k = 1; k <= n; k++) begin
         @(negedge sclk);
         #2;
         din = stim[k];
         if (k == flip_at + 1) sample_data = alt;
         #3;
         rec_dout[k] = dout;
         rec_busy[k] = busy;
         rec_acq[k]  = acquiring;
         rec_oe[k]   = out_en;
         rec_fld[k]  = {chan_sel, low_res, single_ended};
         rec_pwr[k]  = pwr_mode;
         @(posedge sclk);
      end
   endtask

   task automatic deselect(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge sclk);
         #2;
         cs_n = 1'b1;
         din  = k[0];
         #3;
         check_eq("R1", "out_en while deselected", int'(out_en), 0);
         check_eq("R1", "dout while deselected", int'(dout), 0);
         check_eq("R1", "busy while deselected", int'(busy), 0);
         @(posedge sclk);
      end
      @(negedge sclk);
      #2;
      cs_n = 1'b0;
      din  = 1'b0;
      @(posedge sclk);
   endtask

   function automatic logic exp_bit(input logic [11:0] d, input int pos, input int nb);
      if (pos >= 0 && pos < nb) return d[11 - pos];
      return 1'b0;
   endfunction

   function automatic logic [4:0] exp_fld(input logic [4:0] oldf, input logic [7:0] w, input int k);
      logic [7:0] m;
      m = {1'b0, oldf, 2'b00};
      for (int j = 6; j >= 2; j--) if (k >= 9 - j) m[j] = w[j];
      return m[6:2];
   endfunction

   initial begin
      repeat (3) @(posedge sclk);
      #5;
      check_eq("R1", "reset out_en", int'(out_en), 0);
      check_eq("R1", "reset dout", int'(dout), 0);
      check_eq("R1", "reset busy", int'(busy), 0);
      check_eq("R4", "reset pwr_mode", int'(pwr_mode), 0);
      check_eq("R3", "reset fields", int'({chan_sel, low_res, single_ended}), 0);
      @(negedge sclk);
      rst_n = 1'b1;
      #2;
      cs_n = 1'b0;
      @(posedge sclk);

      // R2: zeros on din start nothing
      clear_stim();
      run_seq(6, 64, 12'h000);
      for (int k = 1; k <= 6; k++) begin
         check_eq("R2", "idle busy", int'(rec_busy[k]), 0);
         check_eq("R2", "idle dout", int'(rec_dout[k]), 0);
         check_eq("R2", "idle acquiring", int'(rec_acq[k]), 0);
         check_eq("R1", "out_en while selected", int'(rec_oe[k]), 1);
      end

      // sweep every command word in back-to-back 24-clock frames
      for (int idx = 0; idx < 128; idx++) begin
         logic [7:0]  w;
         logic [11:0] d;
         int          nb;
         string       dreq;
         w  = {1'b1, 7'(idx)};
         d  = 12'((idx * 397 + 1443) % 4096);
         nb = w[3] ? 8 : 12;
         dreq = w[3] ? "R8,R9" : "R7,R9";
         clear_stim();
         put_word(1, w);
         sample_data = d;
         run_seq(24, 8, ~d);
         for (int k = 1; k <= 24; k++) begin
            check_eq(dreq, $sformatf("word %02h dout edge %0d", w, k),
                     int'(rec_dout[k]), int'(exp_bit(d, k - 10, nb)));
            check_eq("R6", $sformatf("word %02h busy edge %0d", w, k),
                     int'(rec_busy[k]), (k == 9) ? 1 : 0);
            check_eq("R5", $sformatf("word %02h acquiring edge %0d", w, k),
                     int'(rec_acq[k]), (k >= 6 && k <= 8) ? 1 : 0);
            check_eq("R3", $sformatf("word %02h fields edge %0d", w, k),
                     int'(rec_fld[k]), int'(exp_fld(cur_fld, w, k)));
            check_eq("R4", $sformatf("word %02h pwr edge %0d", w, k),
                     int'(rec_pwr[k]), (k <= 8) ? int'(cur_pwr) : int'(w[1:0]));
         end
         if (idx > 0) check_eq("R13", "restart without reframing", int'(rec_busy[9]), 1);
         cur_fld = w[6:2];
         cur_pwr = w[1:0];
      end

      // R10 and R4: cancel inside the command word
      clear_stim();
      put_word(1, 8'hD6);
      run_seq(4, 64, 12'h000);
      deselect(3);
      clear_stim();
      sample_data = 12'hFFF;
      run_seq(30, 64, 12'hFFF);
      for (int k = 1; k <= 30; k++) begin
         check_eq("R10", "no busy after early cancel", int'(rec_busy[k]), 0);
         check_eq("R10", "no dout after early cancel", int'(rec_dout[k]), 0);
      end
      cur_fld = {3'b101, cur_fld[1:0]};
      check_eq("R10", "fields kept after early cancel", int'(rec_fld[30]), int'(cur_fld));
      check_eq("R4", "pwr kept after early cancel", int'(rec_pwr[30]), int'(cur_pwr));

      // R10: cancel while the result is shifting out
      clear_stim();
      put_word(1, 8'h9A);
      sample_data = 12'hFFF;
      run_seq(12, 64, 12'hFFF);
      check_eq("R8", "first result bit before cancel", int'(rec_dout[10]), 1);
      deselect(3);
      clear_stim();
      run_seq(30, 64, 12'hFFF);
      for (int k = 1; k <= 30; k++) begin
         check_eq("R10", "no dout after late cancel", int'(rec_dout[k]), 0);
         check_eq("R10", "no busy after late cancel", int'(rec_busy[k]), 0);
      end
      check_eq("R10", "fields kept after late cancel", int'(rec_fld[30]), int'(5'b00110));
      check_eq("R4", "pwr from completed word", int'(rec_pwr[30]), 2);

      // R11 / R12: lockout boundaries for the second start bit
      for (int m = 0; m < 2; m++) begin
         int          thr;
         int          nb;
         string       lreq;
         logic [7:0]  wa, wb;
         logic [11:0] da, db;
         thr  = (m == 1) ? 12 : 16;
         nb   = (m == 1) ? 8 : 12;
         lreq = (m == 1) ? "R12" : "R11";
         wa   = {1'b1, 3'b011, 1'(m), 1'b0, 2'b11};
         wb   = {1'b1, 3'b110, 1'(m), 1'b1, 2'b01};
         da   = 12'hA5C;
         db   = 12'h3E7;

         clear_stim();
         put_word(1, wa);
         stim[thr - 1] = 1'b1;
         sample_data = da;
         run_seq(40, 8, db);
         for (int k = 1; k <= 40; k++) begin
            check_eq(lreq, $sformatf("early start ignored, busy edge %0d", k),
                     int'(rec_busy[k]), (k == 9) ? 1 : 0);
            check_eq(lreq, $sformatf("early start ignored, dout edge %0d", k),
                     int'(rec_dout[k]), int'(exp_bit(da, k - 10, nb)));
         end

         clear_stim();
         put_word(1, wa);
         put_word(thr, wb);
         sample_data = da;
         run_seq(thr + 24, 8, db);
         for (int k = 1; k <= thr + 24; k++) begin
            check_eq(lreq, $sformatf("start at boundary, busy edge %0d", k),
                     int'(rec_busy[k]), (k == 9 || k == thr + 8) ? 1 : 0);
            check_eq(lreq, $sformatf("start at boundary, dout edge %0d", k),
                     int'(rec_dout[k]),
                     int'(exp_bit(da, k - 10, nb) | exp_bit(db, k - thr - 9, nb)));
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge sclk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule